// File: doc/BRIEF.md
# Multicore Wake-Up and Inter-Core Interrupt Controller

This block keeps the run state of every core in a small multicore cluster and carries interrupts from one core to another. Each core has its own control-register port. When a core writes the index of a target core to the send register, that target gets an interrupt. Delivering that interrupt does two things: it records a pending bit in the target's cause register, and it sets the target's run flag. Each core can also read two constant registers through its port. One holds the core's own index and the other holds the number of cores in the cluster.

After reset every core is asleep. A one-cycle host start pulse acts as an interrupt to core 0, which makes core 0 the first core to run. Core 0 can then wake the other cores by sending them interrupts. Each core also has a halt input. Halt puts the core back into its reset state, and the core then stays stopped until a later interrupt reaches it.

Top module: `ipi_run_ctrl`

## Requirements
- R1: While reset is active and directly after it, every bit of `run_vec` is 0 and every cause word is 0.
- R2: A host start pulse in cycle t sets run bit 0 and core 0's pending bit (cause bit PEND_SHIFT+IPI_LINE, bit 13 by default) from cycle t+1.
- R3: A core writes the send register (index 7) with value k, where k is below NCORES. From the next cycle, core k has its run bit set and its pending bit at cause bit 13.
- R4: A send-register write whose value is NCORES or greater changes no run bit and no cause word.
- R5: A write to any index other than 7, including 10 and 12, changes no run bit and no cause word.
- R6: When a core's read index is 10, its `cr_rdata` slice returns that core's own index, zero-extended, in the same cycle.
- R7: When a core's read index is 12, its `cr_rdata` slice returns NCORES. Any index other than 10 or 12 reads 0.
- R8: A halt on core k in cycle t clears run bit k and clears the whole cause word of core k from cycle t+1. The core then stays stopped until an interrupt reaches it.
- R9: An interrupt and a halt can reach the same core in the same cycle. The halt wins, so the run bit becomes 0, but the pending bit is still recorded as the only set cause bit.
- R10: Interrupts from several senders in one cycle, including the host start, are all delivered. Those aimed at the same target merge into one delivery.
- R11: A run bit and its pending bit stay set until that core is halted or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_start | input | 1 | One-cycle host start pulse; acts as an interrupt to core 0 |
| halt_req | input | NCORES | Per-core request to return to the reset state |
| cr_we | input | NCORES | Per-core control-register write strobe |
| cr_idx | input | NCORES*IDX_W | Per-core control-register index, core i in slice i |
| cr_wdata | input | NCORES*XLEN | Per-core write data, core i in slice i |
| cr_rdata | output | NCORES*XLEN | Per-core read data for the index on `cr_idx` (combinational) |
| run_vec | output | NCORES | Run flag of each core |
| cause_flat | output | NCORES*CAUSE_W | Cause word of each core, core i in slice i |

## Verification
Seeded random traffic mixes four kinds of write:
- valid targets,
- out-of-range values just above the core count and far above it,
- writes to the wrong index,
- sporadic halts and start pulses.

Against a bench model, this traffic separates correct routing from an off-by-one range check, from an index decode that is too loose, and from lost merging when several senders hit one target. Directed cycles add four cases:
- a halt colliding with an interrupt, which tells apart the three possible priorities;
- two senders aimed at one core;
- a value exactly equal to the core count, which is the range edge;
- idle cycles after a halt, which show that the stop is sticky.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned CR_SEND_IPI   = 7;
  localparam int unsigned CR_CORE_ID    = 10;
  localparam int unsigned CR_CORE_COUNT = 12;

  // Position of the inter-core pending bit inside a cause word.
  function automatic int unsigned pend_pos(int unsigned shift, int unsigned line);
    return shift + line;
  endfunction

  // True when a send value names target core t.
  function automatic logic ipi_targets(logic [63:0] value, int unsigned t);
    return value == 64'(t);
  endfunction
endpackage

// File: rtl/ipi_router.sv
module ipi_router
  import ipi_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                    host_start,
  input  logic [NCORES-1:0]       cr_we,
  input  logic [NCORES*IDX_W-1:0] cr_idx,
  input  logic [NCORES*XLEN-1:0]  cr_wdata,
  output logic [NCORES-1:0]       ipi_send,
  output logic [NCORES-1:0]       ipi_hit
);
  for (genvar s = 0; s < NCORES; s++) begin : g_send
    assign ipi_send[s] = cr_we[s] &&
                         (cr_idx[s*IDX_W +: IDX_W] == IDX_W'(CR_SEND_IPI));
  end

  always_comb begin
    ipi_hit    = '0;
    ipi_hit[0] = host_start;
    for (int t = 0; t < int'(NCORES); t++) begin
      for (int s = 0; s < int'(NCORES); s++) begin
        if (ipi_send[s] && ipi_targets(64'(cr_wdata[s*XLEN +: XLEN]), t))
          ipi_hit[t] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/core_run_state.sv
module core_run_state #(
  parameter int unsigned CAUSE_W  = 32,
  parameter int unsigned PEND_BIT = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ipi_hit,
  input  logic               halt,
  output logic               run,
  output logic [CAUSE_W-1:0] cause
);
  localparam logic [CAUSE_W-1:0] PEND_MASK = CAUSE_W'(1) << PEND_BIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cause <= '0;
    end else if (halt) begin
      run   <= 1'b0;
      cause <= ipi_hit ? PEND_MASK : '0;
    end else if (ipi_hit) begin
      run   <= 1'b1;
      cause <= cause | PEND_MASK;
    end
  end
endmodule

// File: rtl/cr_readback.sv
module cr_readback
  import ipi_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned NCORES  = 4,
  parameter int unsigned CORE_ID = 0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  rdata
);
  always_comb begin
    if (idx == IDX_W'(CR_CORE_ID))         rdata = XLEN'(CORE_ID);
    else if (idx == IDX_W'(CR_CORE_COUNT)) rdata = XLEN'(NCORES);
    else                                   rdata = '0;
  end
endmodule

// File: rtl/ipi_run_ctrl.sv
module ipi_run_ctrl
  import ipi_pkg::*;
#(
  parameter int unsigned NCORES     = 4,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned CAUSE_W    = 32,
  parameter int unsigned PEND_SHIFT = 8,
  parameter int unsigned IPI_LINE   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_start,
  input  logic [NCORES-1:0]         halt_req,
  input  logic [NCORES-1:0]         cr_we,
  input  logic [NCORES*IDX_W-1:0]   cr_idx,
  input  logic [NCORES*XLEN-1:0]    cr_wdata,
  output logic [NCORES*XLEN-1:0]    cr_rdata,
  output logic [NCORES-1:0]         run_vec,
  output logic [NCORES*CAUSE_W-1:0] cause_flat
);
  localparam int unsigned PEND_BIT = pend_pos(PEND_SHIFT, IPI_LINE);

  logic [NCORES-1:0] ipi_send;
  logic [NCORES-1:0] ipi_hit;

  ipi_router #(.NCORES(NCORES), .XLEN(XLEN), .IDX_W(IDX_W)) u_router (
    .host_start(host_start),
    .cr_we     (cr_we),
    .cr_idx    (cr_idx),
    .cr_wdata  (cr_wdata),
    .ipi_send  (ipi_send),
    .ipi_hit   (ipi_hit)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    core_run_state #(.CAUSE_W(CAUSE_W), .PEND_BIT(PEND_BIT)) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .ipi_hit(ipi_hit[c]),
      .halt   (halt_req[c]),
      .run    (run_vec[c]),
      .cause  (cause_flat[c*CAUSE_W +: CAUSE_W])
    );

    cr_readback #(.XLEN(XLEN), .IDX_W(IDX_W), .NCORES(NCORES), .CORE_ID(c)) u_rd (
      .idx  (cr_idx[c*IDX_W +: IDX_W]),
      .rdata(cr_rdata[c*XLEN +: XLEN])
    );
  end
endmodule

// File: rtl/ipi_run_ctrl_chk.sv
module ipi_run_ctrl_chk
  import ipi_pkg::*;
#(
  parameter int unsigned NCORES   = 4,
  parameter int unsigned XLEN     = 32,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned CAUSE_W  = 32,
  parameter int unsigned PEND_BIT = 13
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      host_start,
  input logic [NCORES-1:0]         halt_req,
  input logic [NCORES-1:0]         ipi_hit,
  input logic [NCORES-1:0]         ipi_send,
  input logic [NCORES*IDX_W-1:0]   cr_idx,
  input logic [NCORES*XLEN-1:0]    cr_rdata,
  input logic [NCORES-1:0]         run_vec,
  input logic [NCORES*CAUSE_W-1:0] cause_flat
);
  a_r2_start_hits_core0: assert property (@(posedge clk) disable iff (!rst_n)
    host_start |-> ipi_hit[0]);

  for (genvar i = 0; i < NCORES; i++) begin : g_chk
    a_r3_hit_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_hit[i] && !halt_req[i]) |=> (run_vec[i] && cause_flat[i*CAUSE_W + PEND_BIT]));

    a_r4_no_spurious_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_vec[i] && !ipi_hit[i]) |=> !run_vec[i]);

    a_r8_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req[i] && !ipi_hit[i]) |=> (!run_vec[i] && cause_flat[i*CAUSE_W +: CAUSE_W] == '0));

    a_r9_halt_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req[i] && ipi_hit[i]) |=> (!run_vec[i] &&
        $countones(cause_flat[i*CAUSE_W +: CAUSE_W]) == 1 && cause_flat[i*CAUSE_W + PEND_BIT]));

    a_r11_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (run_vec[i] && !halt_req[i]) |=> run_vec[i]);

    a_r6_id_read: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_idx[i*IDX_W +: IDX_W] == IDX_W'(CR_CORE_ID)) |-> (cr_rdata[i*XLEN +: XLEN] == XLEN'(i)));

    a_r7_count_read: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_idx[i*IDX_W +: IDX_W] == IDX_W'(CR_CORE_COUNT)) |-> (cr_rdata[i*XLEN +: XLEN] == XLEN'(NCORES)));
  end

  a_r10_send_delivered: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_send == '0 && !host_start) |-> (ipi_hit == '0));
endmodule

bind ipi_run_ctrl ipi_run_ctrl_chk #(
  .NCORES(NCORES), .XLEN(XLEN), .IDX_W(IDX_W), .CAUSE_W(CAUSE_W), .PEND_BIT(PEND_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_start(host_start), .halt_req(halt_req),
  .ipi_hit(ipi_hit), .ipi_send(ipi_send), .cr_idx(cr_idx), .cr_rdata(cr_rdata),
  .run_vec(run_vec), .cause_flat(cause_flat)
);

// File: tb/ipi_run_ctrl_bench.sv
module ipi_run_ctrl_bench;
  localparam int NC = 4;
  localparam int XW = 32;
  localparam int IW = 5;
  localparam int CW = 32;
  localparam int PB = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_start = 1'b0;
  logic [NC-1:0] halt_req = '0;
  logic [NC-1:0] cr_we = '0;
  logic [NC*IW-1:0] cr_idx = '0;
  logic [NC*XW-1:0] cr_wdata = '0;
  logic [NC*XW-1:0] cr_rdata;
  logic [NC-1:0] run_vec;
  logic [NC*CW-1:0] cause_flat;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [NC-1:0] exp_run = '0;
  logic [NC-1:0] exp_pend = '0;

  always #5 clk = ~clk;

  ipi_run_ctrl u_ipi_run_ctrl (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .halt_req(halt_req),
    .cr_we(cr_we), .cr_idx(cr_idx), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
    .run_vec(run_vec), .cause_flat(cause_flat)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [XW-1:0] exp_read(int core, logic [IW-1:0] idx);
    if (idx == 5'd10) return XW'(core);
    if (idx == 5'd12) return XW'(NC);
    return '0;
  endfunction

  // Which cores receive an interrupt from the inputs now applied.
  function automatic logic [NC-1:0] targets_now();
    logic [NC-1:0] g = '0;
    if (host_start) g[0] = 1'b1;
    for (int s = 0; s < NC; s++)
      if (cr_we[s] && cr_idx[s*IW +: IW] == 5'd7 && cr_wdata[s*XW +: XW] < XW'(NC))
        g[cr_wdata[s*XW +: 2]] = 1'b1;
    return g;
  endfunction

  task automatic set_src(int s, logic we, logic [IW-1:0] idx, logic [XW-1:0] d);
    cr_we[s] = we;
    cr_idx[s*IW +: IW] = idx;
    cr_wdata[s*XW +: XW] = d;
  endtask

  task automatic clear_inputs();
    host_start = 1'b0;
    halt_req = '0;
    cr_we = '0;
    cr_idx = '0;
    cr_wdata = '0;
  endtask

  // Inputs are already applied; check reads, advance one edge, check state.
  task automatic cycle(string req);
    logic [NC-1:0] g;
    #1;
    for (int c = 0; c < NC; c++)
      check((cr_idx[c*IW +: IW] == 5'd10) ? "R6" : "R7",
            64'(cr_rdata[c*XW +: XW]), 64'(exp_read(c, cr_idx[c*IW +: IW])));
    g = targets_now();
    for (int c = 0; c < NC; c++) begin
      if (halt_req[c]) begin
        exp_run[c] = 1'b0;
        exp_pend[c] = g[c];
      end else if (g[c]) begin
        exp_run[c] = 1'b1;
        exp_pend[c] = 1'b1;
      end
    end
    @(posedge clk);
    #2;
    check(req, 64'(run_vec), 64'(exp_run));
    for (int c = 0; c < NC; c++)
      check(req, 64'(cause_flat[c*CW +: CW]), 64'(exp_pend[c]) << PB);
    clear_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h1234_5eed);
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1", 64'(run_vec), 64'(0));
    for (int c = 0; c < NC; c++) check("R1", 64'(cause_flat[c*CW +: CW]), 64'(0));
    rst_n = 1'b1;
    cycle("R1");
    // R6 / R7 reads, R5 writes to read-only indices ignored
    for (int c = 0; c < NC; c++) set_src(c, 1'b1, 5'd10, 32'd1);
    cycle("R5");
    for (int c = 0; c < NC; c++) set_src(c, 1'b1, 5'd12, 32'd2);
    cycle("R5");
    set_src(2, 1'b1, 5'd6, 32'd1);
    cycle("R5");
    // R2 start
    host_start = 1'b1;
    cycle("R2");
    // R4 range edge
    set_src(0, 1'b1, 5'd7, 32'd4);
    cycle("R4");
    set_src(0, 1'b1, 5'd7, 32'hFFFF_FFFF);
    cycle("R4");
    // R3 / R10: two senders to core 3, one to core 1
    set_src(0, 1'b1, 5'd7, 32'd3);
    set_src(2, 1'b1, 5'd7, 32'd3);
    set_src(3, 1'b1, 5'd7, 32'd1);
    cycle("R10");
    // R9 halt wins over a simultaneous interrupt
    halt_req[3] = 1'b1;
    set_src(0, 1'b1, 5'd7, 32'd3);
    cycle("R9");
    // R8 halt then idle: stays stopped
    halt_req[1] = 1'b1;
    cycle("R8");
    repeat (3) cycle("R8");
    cycle("R11");
    // Random traffic
    for (int n = 0; n < 400; n++) begin
      for (int s = 0; s < NC; s++) begin
        logic [31:0] r;
        logic [IW-1:0] ix;
        logic [XW-1:0] d;
        r = $urandom;
        case (r[2:0])
          3'd0, 3'd1, 3'd2: ix = 5'd7;
          3'd3: ix = 5'd10;
          3'd4: ix = 5'd12;
          default: ix = IW'(r[7:3]);
        endcase
        case (r[10:8])
          3'd0: d = 32'd4;
          3'd1: d = {r[31:12], 12'hFFF};
          default: d = XW'(r[12:11]);
        endcase
        set_src(s, r[13] | r[14], ix, d);
        halt_req[s] = (r[19:15] == 5'd0);
      end
      host_start = ($urandom_range(0, 15) == 0);
      cycle("R3/R10/R11");
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule